// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device has left stuck, typically with SDA held low in the middle of a byte, before a bus controller is allowed to use the pins. A one-cycle start request launches a fixed sequence. Both lines are first sampled through a two-flop synchronizer. If the bus is already idle, the sequence ends successfully at once. Otherwise the block clocks SCL through a fixed number of open-drain pulses, so that the stuck target can shift out its remaining bits and release SDA. It then watches both lines for a bounded time and reports either success or a busy error.

While the sequence runs, an ownership output tells an external pin multiplexer to route SCL to this block. SCL is only ever pulled low or released, never driven high. SDA is observed but never driven. The block does not generate START or STOP conditions, and it does not take over from a running controller. The low time, release time and final timeout are parameters counted in system clock cycles.

The state machine has seven states. IDLE goes to CHECK on a start request. CHECK goes to DONE when both lines are high, and to PULL otherwise. PULL goes to RELEASE when the low time expires. RELEASE goes to PULL when the release time expires and pulses remain, and to WAIT_IDLE after the last pulse. WAIT_IDLE goes to DONE when both lines read high, and to FAIL when the timeout expires. DONE and FAIL return to IDLE after one cycle.

Top module: `bus_recovery_seq`

## Requirements
- R1: After reset, `own_o`, `scl_pull_o`, `done_o` and `err_o` are all low.
- R2: When a start request finds both synchronized lines high, `done_o` pulses two cycles after the request cycle. No SCL pulse is produced, and `own_o` is high for exactly one cycle.
- R3: When either line is low at the check, exactly `PULSES` (default 9) SCL pulses are produced before the sequence ends.
- R4: Each pulse holds `scl_pull_o` high (SCL pulled low) for exactly `LOW_CYCLES` cycles. Consecutive pulses are separated by exactly `REL_CYCLES` cycles with SCL released.
- R5: `own_o` is high from the cycle after the start request until the cycle before the `done_o`/`err_o` pulse. `scl_pull_o` is high only while `own_o` is high.
- R6: After the last pulse and its release time, the block pulses `done_o` as soon as both synchronized lines read high. If they do not within `TIMEOUT_CYCLES` cycles, it pulses `err_o` instead. With lines stuck, `own_o` is high for 1 + PULSES*(LOW_CYCLES+REL_CYCLES) + TIMEOUT_CYCLES cycles.
- R7: `sda_pull_o` stays low at all times, so SDA is never driven.
- R8: A start request arriving while `own_o` is high is ignored. The pulse count and duration of the running sequence are unchanged, and no second completion follows.
- R9: `done_o` and `err_o` are single-cycle pulses and are never high together. Exactly one of them follows each accepted start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the recovery sequence |
| scl_i | input | 1 | SCL line level as seen at the pad (asynchronous) |
| sda_i | input | 1 | SDA line level as seen at the pad (asynchronous) |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it (open drain) |
| sda_pull_o | output | 1 | SDA pull-down enable, held low |
| own_o | output | 1 | Pin ownership request to the pad multiplexer |
| done_o | output | 1 | One-cycle pulse: bus found or made idle |
| err_o | output | 1 | One-cycle pulse: bus still busy at timeout |

## Verification
The assertions assume that `start_i` is a synchronous pulse and that the line inputs change only slowly compared with the clock. This lets the synchronizer show a settled level at each check. The bench changes line levels only at falling clock edges, and always several cycles before the sample that matters. It models the wired line as the external level ANDed with the block's pull, and it releases a stuck SDA only after a chosen number of observed pulses or after a fixed delay. Start requests inside a running sequence are issued on purpose, to exercise the ignore rule.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PULL,
        ST_RELEASE,
        ST_WAIT_IDLE,
        ST_DONE,
        ST_FAIL
    } brc_state_t;
endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // Lines idle high, so the stages reset to 1.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/brc_timer.sv
module brc_timer #(
    parameter int MAX_LOAD = 16,
    localparam int TW = $clog2(MAX_LOAD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= load_val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    assert_timer_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(MAX_LOAD));

    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq #(
    parameter int PULSES         = 9,
    parameter int LOW_CYCLES     = 12500,
    parameter int REL_CYCLES     = 12500,
    parameter int TIMEOUT_CYCLES = 50000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic own_o,
    output logic done_o,
    output logic err_o
);
    import brc_pkg::*;

    localparam int MAX_HALF = (LOW_CYCLES > REL_CYCLES) ? LOW_CYCLES : REL_CYCLES;
    localparam int MAX_LOAD = (MAX_HALF > TIMEOUT_CYCLES) ? MAX_HALF : TIMEOUT_CYCLES;
    localparam int TW       = $clog2(MAX_LOAD + 1);
    localparam int PW       = $clog2(PULSES + 1);

    brc_state_t    state, state_nx;
    logic [1:0]    lines_s;
    logic          bus_idle;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [PW-1:0] pulse_cnt;
    logic          cnt_clr, cnt_inc;

    brc_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    assign bus_idle = lines_s[1] & lines_s[0];

    brc_timer #(.MAX_LOAD(MAX_LOAD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pulse_cnt <= '0;
        else if (cnt_clr) pulse_cnt <= '0;
        else if (cnt_inc) pulse_cnt <= pulse_cnt + 1'b1;
    end

    // Next state and timer control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (bus_idle) begin
                    state_nx = ST_DONE;
                end else begin
                    state_nx = ST_PULL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LOW_CYCLES - 1);
                    cnt_clr  = 1'b1;
                end
            end
            ST_PULL: begin
                if (tmr_zero) begin
                    state_nx = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(REL_CYCLES - 1);
                end
            end
            ST_RELEASE: begin
                if (tmr_zero) begin
                    if (pulse_cnt == PW'(PULSES - 1)) begin
                        state_nx = ST_WAIT_IDLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(TIMEOUT_CYCLES - 1);
                    end else begin
                        state_nx = ST_PULL;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LOW_CYCLES - 1);
                        cnt_inc  = 1'b1;
                    end
                end
            end
            ST_WAIT_IDLE: begin
                if (bus_idle)      state_nx = ST_DONE;
                else if (tmr_zero) state_nx = ST_FAIL;
            end
            ST_DONE: state_nx = ST_IDLE;
            ST_FAIL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        scl_pull_o = 1'b0;
        own_o      = 1'b0;
        done_o     = 1'b0;
        err_o      = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_CHECK:     own_o = 1'b1;
            ST_PULL:      begin own_o = 1'b1; scl_pull_o = 1'b1; end
            ST_RELEASE:   own_o = 1'b1;
            ST_WAIT_IDLE: own_o = 1'b1;
            ST_DONE:      done_o = 1'b1;
            ST_FAIL:      err_o  = 1'b1;
            default:      ;
        endcase
    end

    assign sda_pull_o = 1'b0;

    assert_pull_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> own_o);

    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt < PW'(PULSES));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !(done_o || err_o));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && start_i) |=> (own_o || done_o || err_o));

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && bus_idle) |=> (done_o && !scl_pull_o));
endmodule

// File: tb/bus_recovery_seq_tb.sv
module bus_recovery_seq_tb;
    localparam int PULSES = 9;
    localparam int LOWC   = 6;
    localparam int RELC   = 6;
    localparam int TOUT   = 300;
    localparam int FULL   = 1 + PULSES * (LOWC + RELC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_ext = 1'b1;
    logic sda_ext = 1'b1;
    logic scl_pull_o, sda_pull_o, own_o, done_o, err_o;
    wire  scl_line = scl_ext & ~scl_pull_o;
    wire  sda_line = sda_ext & ~sda_pull_o;

    always #2 clk = ~clk; // 250 MHz

    bus_recovery_seq #(
        .PULSES(PULSES), .LOW_CYCLES(LOWC), .REL_CYCLES(RELC), .TIMEOUT_CYCLES(TOUT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
        .own_o(own_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct {
        bit    is_err;
        int    pulses;
        int    own;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int events_seen = 0;
    int release_after = -1;
    bit wd_hit = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    int  pulses = 0, own_cnt = 0, low_run = 0, rel_run = 0;
    bit  prev_pull = 1'b0, bad_low = 1'b0, bad_rel = 1'b0, in_rel = 1'b0;
    bit  sda_driven = 1'b0, pull_unowned = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_pull_o) sda_driven = 1'b1;
            if (scl_pull_o && !own_o) pull_unowned = 1'b1;
            if (own_o) own_cnt++;
            if (scl_pull_o && !prev_pull) begin
                pulses++;
                if (in_rel && rel_run != RELC) bad_rel = 1'b1;
                in_rel  = 1'b0;
                low_run = 1;
            end else if (scl_pull_o) begin
                low_run++;
            end else if (prev_pull) begin
                if (low_run != LOWC) bad_low = 1'b1;
                in_rel  = 1'b1;
                rel_run = 1;
            end else if (in_rel) begin
                rel_run++;
            end
            prev_pull = scl_pull_o;
            if (release_after >= 0 && pulses >= release_after) sda_ext = 1'b1;
            if (done_o && err_o) check(1'b0, "R9 both pulses", 1, 0);
            if (done_o || err_o) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(err_o == e.is_err, {e.req, " R6 outcome err"}, int'(err_o), int'(e.is_err));
                    check(pulses == e.pulses, {e.req, " R3 pulse count"}, pulses, e.pulses);
                    if (e.own >= 0)
                        check(own_cnt == e.own, {e.req, " R5 own cycles"}, own_cnt, e.own);
                    check(!bad_low && !bad_rel, {e.req, " R4 pulse timing"}, int'(bad_low) + 2*int'(bad_rel), 0);
                    check(!pull_unowned, {e.req, " R5 pull without own"}, 1, 0);
                end
                pulses = 0; own_cnt = 0; bad_low = 1'b0; bad_rel = 1'b0;
                in_rel = 1'b0; pull_unowned = 1'b0;
                events_seen++;
            end
        end
    end

    // Driver
    task automatic run_case(input bit scl_lvl, input bit sda_lvl, input int rel_after,
                            input int late_release, input bit exp_err, input int exp_pulses,
                            input int exp_own, input bit mid_start, input string req);
        int seen;
        exp_t e;
        @(negedge clk);
        scl_ext = scl_lvl;
        sda_ext = sda_lvl;
        release_after = rel_after;
        repeat (5) @(negedge clk);
        e.is_err = exp_err; e.pulses = exp_pulses; e.own = exp_own; e.req = req;
        q.push_back(e);
        seen = events_seen;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        if (late_release > 0) begin
            repeat (late_release) @(negedge clk);
            sda_ext = 1'b1;
        end
        while (events_seen == seen && !wd_hit) @(negedge clk);
        release_after = -1;
        repeat (30) @(negedge clk);
        check(events_seen == seen + 1, {req, " R8/R9 one completion"}, events_seen - seen, 1);
        check(!own_o && !scl_pull_o, {req, " R5 idle after end"}, int'(own_o), 0);
        scl_ext = 1'b1;
        sda_ext = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        wd_hit = 1'b1;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!own_o && !scl_pull_o && !done_o && !err_o, "R1 reset outputs",
              int'({own_o, scl_pull_o, done_o, err_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!own_o && !scl_pull_o && !done_o && !err_o, "R1 after reset release",
              int'({own_o, scl_pull_o, done_o, err_o}), 0);
        // R2: idle bus exits at once
        run_case(1'b1, 1'b1, -1, 0, 1'b0, 0, 1, 1'b0, "R2 idle bus");
        // R3/R6: SDA stuck, target lets go after 3 pulses
        run_case(1'b1, 1'b0, 3, 0, 1'b0, PULSES, FULL + 1, 1'b0, "R3 sda freed early");
        // R6: SDA stuck for good -> timeout
        run_case(1'b1, 1'b0, -1, 0, 1'b1, PULSES, FULL + TOUT, 1'b0, "R6 sda stuck timeout");
        // R6: SCL held low externally -> timeout
        run_case(1'b0, 1'b1, -1, 0, 1'b1, PULSES, FULL + TOUT, 1'b0, "R6 scl stuck timeout");
        // R6: SDA freed during the final wait
        run_case(1'b1, 1'b0, -1, FULL + 100, 1'b0, PULSES, -1, 1'b0, "R6 freed in wait");
        // R8: start during a running sequence ignored
        run_case(1'b1, 1'b0, 5, 0, 1'b0, PULSES, FULL + 1, 1'b1, "R8 restart ignored");
        // R8: restart during stuck sequence does not extend it
        run_case(1'b1, 1'b0, -1, 0, 1'b1, PULSES, FULL + TOUT, 1'b1, "R8 restart stuck");
        // R2 again after the others
        run_case(1'b1, 1'b1, -1, 0, 1'b0, 0, 1, 1'b0, "R2 idle again");
        check(!sda_driven, "R7 sda never driven", int'(sda_driven), 0);
        check(q.size() == 0, "R9 all expected completions seen", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule